// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns bytes into asynchronous serial frames. A host programs a line-configuration register and then writes a byte into a single holding register. When the serializer is idle, it moves the byte out of the holding register and sends a frame on the line. The frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one, one-and-a-half or two high stop bits. The parity bit can be odd, even, forced high or forced low.

An external baud generator sets the timing. It supplies one tick per oversample period, and each serial bit lasts 16 ticks. The block holds the 16-bit divisor for that generator and drives it on an output port.

The top bit of the configuration register switches the two lowest register addresses. When it is 1, those addresses reach the divisor bytes instead of the data path and the interrupt-enable byte. A break bit forces the line low. While break is set, the frame timing continues underneath it.

Top module: `lcr_uart_tx`

## Requirements
- R1: After reset the line is high, `tx_busy` is 0 and `thr_empty` is 1. The configuration register reads 0x00, the interrupt-enable byte reads 0x00 and `dl_value` is 0x0000.
- R2: A frame starts with a low bit and then sends N data bits, least significant first. N is 5 plus the value of configuration bits [1:0]. Every bit lasts 16 baud ticks. Data bits above N are not sent.
- R3: When configuration bit 3 is 0, no parity bit is sent, whatever the values of bits [5:4].
- R4: Configuration bits [5:3] = 3'b001 send odd parity, and 3'b011 send even parity. Both are computed over the N configured data bits only.
- R5: Configuration bits [5:3] = 3'b101 send a parity bit that is always 1. The value 3'b111 sends a parity bit that is always 0.
- R6: When configuration bit 2 is 0, the stop time is 16 ticks. When it is 1, the stop time is 32 ticks, or 24 ticks when N is 5. `tx_busy` is high from the first start-bit cycle through the last stop tick.
- R7: In a cycle with no baud tick, an active frame does not advance. The line level and `tx_busy` hold.
- R8: While configuration bit 6 is 1, the line is low, both when idle and during a frame. The frame keeps its timing underneath, and the line shows the current frame bit again as soon as bit 6 is cleared.
- R9: While configuration bit 7 is 1:
  - address 0 reads and writes divisor bits [7:0], and address 1 reads and writes divisor bits [15:8];
  - a write to address 0 does not load the holding register;
  - a write to address 1 leaves the interrupt-enable byte unchanged.
- R10: While configuration bit 7 is 0:
  - a write to address 0 loads the holding register, and `thr_empty` falls on the next cycle;
  - address 1 holds a 4-bit interrupt-enable field that reads back zero-extended;
  - a read of address 0 returns 0x00.
- R11: Address 3 holds the 8-bit configuration register, which reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data, combinational from `addr` |
| baud_tick | input | 1 | One pulse per oversample period |
| ser_out | output | 1 | Serial line, idles high |
| tx_busy | output | 1 | A frame is in progress |
| thr_empty | output | 1 | Holding register can accept a byte |
| dl_value | output | 16 | Divisor for the external baud generator |

## Verification
The bench records the line and `tx_busy` in every cycle of a frame and compares them with a timeline built from the configuration. This catches several kinds of error:
- a parity computed over all eight bits, or with the odd and even senses swapped;
- the two forced-parity values swapped;
- a parity bit sent while bit 3 is clear;
- a 24-tick stop time used for every word length, or for none.

Break is asserted and released in the middle of a frame. A design that freezes the serializer during break, or that restarts the frame afterwards, would finish at the wrong cycle. Baud ticks are withheld for a stretch, and the frame end must move by exactly that many cycles. With the divisor access bit set, writes to address 0 must leave `thr_empty` high and the line idle, and writes to address 1 must leave the interrupt-enable byte unchanged.

// File: rtl/lcr_uart_pkg.sv
package lcr_uart_pkg;
    localparam int ADDR_W = 3;
    localparam int BYTE_W = 8;

    localparam logic [ADDR_W-1:0] ADDR_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_IER  = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_CFG  = 3'd3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP
    } tx_phase_e;

    // Low six configuration bits, in register order.
    typedef struct packed {
        logic [1:0] par_mode;   // 00 odd, 01 even, 10 forced 1, 11 forced 0
        logic       par_en;
        logic       long_stop;
        logic [1:0] word_sel;   // N = 5 + word_sel
    } frame_cfg_t;
endpackage

// File: rtl/lcr_uart_parity.sv
module lcr_uart_parity
    import lcr_uart_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        word_sel,
    input  logic [1:0]        par_mode,
    output logic              par_bit
);
    logic [DATA_W-1:0] mask;
    logic              ones_odd;

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            mask[i] = (i < (5 + int'(word_sel)));
        end
        ones_odd = ^(data & mask);
        unique case (par_mode)
            2'b00:   par_bit = ~ones_odd;  // odd
            2'b01:   par_bit = ones_odd;   // even
            2'b10:   par_bit = 1'b1;
            default: par_bit = 1'b0;
        endcase
    end
endmodule

// File: rtl/lcr_uart_regs.sv
module lcr_uart_regs
    import lcr_uart_pkg::*;
#(
    parameter int IER_W = 4,
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] cfg,
    output logic [DIV_W-1:0]  divisor,
    output logic              thr_wr,
    output logic [BYTE_W-1:0] rdata
);
    localparam int DIV_HI_W = DIV_W - BYTE_W;

    typedef struct packed {
        logic [BYTE_W-1:0]   cfg;
        logic [IER_W-1:0]    ier;
        logic [BYTE_W-1:0]   div_lo;
        logic [DIV_HI_W-1:0] div_hi;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  remap;

    assign remap = regs_q.cfg[BYTE_W-1];

    always_comb begin
        regs_d = regs_q;
        thr_wr = 1'b0;
        if (wr_en) begin
            unique case (addr)
                ADDR_DATA: begin
                    if (remap) regs_d.div_lo = wdata;
                    else       thr_wr = 1'b1;
                end
                ADDR_IER: begin
                    if (remap) regs_d.div_hi = wdata[DIV_HI_W-1:0];
                    else       regs_d.ier = wdata[IER_W-1:0];
                end
                ADDR_CFG: regs_d.cfg = wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_DATA: if (remap) rdata = regs_q.div_lo;
            ADDR_IER: begin
                if (remap) rdata[DIV_HI_W-1:0] = regs_q.div_hi;
                else       rdata[IER_W-1:0] = regs_q.ier;
            end
            ADDR_CFG: rdata = regs_q.cfg;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign cfg     = regs_q.cfg;
    assign divisor = {regs_q.div_hi, regs_q.div_lo};
endmodule

// File: rtl/lcr_uart_ser.sv
module lcr_uart_ser
    import lcr_uart_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_W     = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              thr_wr,
    input  logic [DATA_W-1:0] thr_data,
    input  frame_cfg_t        cfg_in,
    input  logic              brk,
    output logic              ser_out,
    output logic              tx_busy,
    output logic              thr_empty
);
    localparam int TICK_W = $clog2(2 * OVERSAMPLE);
    localparam int IDX_W  = $clog2(DATA_W);
    localparam logic [TICK_W-1:0] BIT_LAST  = TICK_W'(OVERSAMPLE - 1);
    localparam logic [TICK_W-1:0] STOP_MID  = TICK_W'(OVERSAMPLE + OVERSAMPLE / 2 - 1);
    localparam logic [TICK_W-1:0] STOP_LONG = TICK_W'(2 * OVERSAMPLE - 1);

    typedef struct packed {
        tx_phase_e         phase;
        logic [TICK_W-1:0] tick_cnt;
        logic [IDX_W-1:0]  bit_idx;
        logic [DATA_W-1:0] shift;
        frame_cfg_t        cfg;
        logic              par_bit;
        logic [DATA_W-1:0] hold;
        logic              hold_full;
    } ser_t;

    ser_t s_d, s_q;
    logic              par_calc;
    logic [TICK_W-1:0] tick_last;
    logic [IDX_W-1:0]  idx_last;
    logic              level;

    lcr_uart_parity #(.DATA_W(DATA_W)) par_i (
        .data     (s_q.hold),
        .word_sel (cfg_in.word_sel),
        .par_mode (cfg_in.par_mode),
        .par_bit  (par_calc)
    );

    always_comb begin
        if (s_q.phase != PH_STOP)       tick_last = BIT_LAST;
        else if (!s_q.cfg.long_stop)    tick_last = BIT_LAST;
        else if (s_q.cfg.word_sel == 0) tick_last = STOP_MID;
        else                            tick_last = STOP_LONG;
        idx_last = IDX_W'(4 + int'(s_q.cfg.word_sel));
    end

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (s_q.hold_full) begin
                    s_d.phase     = PH_START;
                    s_d.tick_cnt  = '0;
                    s_d.shift     = s_q.hold;
                    s_d.cfg       = cfg_in;
                    s_d.par_bit   = par_calc;
                    s_d.hold_full = 1'b0;
                end
            end
            default: begin
                if (baud_tick) begin
                    if (s_q.tick_cnt != tick_last) begin
                        s_d.tick_cnt = s_q.tick_cnt + 1'b1;
                    end else begin
                        s_d.tick_cnt = '0;
                        unique case (s_q.phase)
                            PH_START: begin
                                s_d.phase   = PH_DATA;
                                s_d.bit_idx = '0;
                            end
                            PH_DATA: begin
                                s_d.shift = s_q.shift >> 1;
                                if (s_q.bit_idx == idx_last)
                                    s_d.phase = s_q.cfg.par_en ? PH_PARITY : PH_STOP;
                                else
                                    s_d.bit_idx = s_q.bit_idx + 1'b1;
                            end
                            PH_PARITY: s_d.phase = PH_STOP;
                            default:   s_d.phase = PH_IDLE;
                        endcase
                    end
                end
            end
        endcase
        if (thr_wr) begin
            s_d.hold      = thr_data;
            s_d.hold_full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        unique case (s_q.phase)
            PH_START:  level = 1'b0;
            PH_DATA:   level = s_q.shift[0];
            PH_PARITY: level = s_q.par_bit;
            default:   level = 1'b1;
        endcase
    end

    assign ser_out   = level & ~brk;
    assign tx_busy   = (s_q.phase != PH_IDLE);
    assign thr_empty = ~s_q.hold_full;
endmodule

// File: rtl/lcr_uart_tx.sv
module lcr_uart_tx
    import lcr_uart_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int IER_W      = 4,
    parameter int DIV_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              baud_tick,
    output logic              ser_out,
    output logic              tx_busy,
    output logic              thr_empty,
    output logic [DIV_W-1:0]  dl_value
);
    logic [BYTE_W-1:0] cfg_w;
    logic              thr_wr_w;

    lcr_uart_regs #(.IER_W(IER_W), .DIV_W(DIV_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .cfg     (cfg_w),
        .divisor (dl_value),
        .thr_wr  (thr_wr_w),
        .rdata   (rdata)
    );

    lcr_uart_ser #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(BYTE_W)) ser_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .thr_wr    (thr_wr_w),
        .thr_data  (wdata),
        .cfg_in    (frame_cfg_t'(cfg_w[5:0])),
        .brk       (cfg_w[6]),
        .ser_out   (ser_out),
        .tx_busy   (tx_busy),
        .thr_empty (thr_empty)
    );
endmodule

// File: rtl/lcr_uart_tx_chk.sv
module lcr_uart_tx_chk
    import lcr_uart_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              baud_tick,
    input logic              ser_out,
    input logic              tx_busy,
    input logic              thr_empty,
    input logic [BYTE_W-1:0] cfg_val
);
    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && !cfg_val[6]) |-> ser_out);

    // R2
    start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> (!ser_out || cfg_val[6]));

    // R7
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && !baud_tick && !wr_en) |=> ($stable(ser_out) && tx_busy));

    // R8
    break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_val[6] |-> !ser_out);

    // R9
    remap_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_DATA && cfg_val[7] && thr_empty) |=> thr_empty);

    // R10
    hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_DATA && !cfg_val[7]) |=> !thr_empty);
endmodule

bind lcr_uart_tx lcr_uart_tx_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .baud_tick (baud_tick),
    .ser_out   (ser_out),
    .tx_busy   (tx_busy),
    .thr_empty (thr_empty),
    .cfg_val   (cfg_w)
);

// File: tb/lcr_uart_tx_tb_top.sv
`timescale 1ns/1ps
module lcr_uart_tx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        baud_tick = 1'b1;
    logic        ser_out;
    logic        tx_busy;
    logic        thr_empty;
    logic [15:0] dl_value;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    lcr_uart_tx dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .baud_tick (baud_tick),
        .ser_out   (ser_out),
        .tx_busy   (tx_busy),
        .thr_empty (thr_empty),
        .dl_value  (dl_value)
    );

    // {config, data}
    localparam logic [15:0] VEC [10] = '{
        16'h03A5, 16'h0015, 16'h042C, 16'h0F3A, 16'h1AF3,
        16'h2900, 16'h3DFF, 16'h3381, 16'h09C0, 16'h1817
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    function automatic logic frame_bit(int k, logic [7:0] d, int n, bit p, logic pb);
        if (k == 0)            return 1'b0;
        if (k <= n)            return d[k-1];
        if (p && k == n + 1)   return pb;
        return 1'b1;
    endfunction

    task automatic run_frame(input logic [7:0] cfg, input logic [7:0] d,
                             input int brk_on, input int brk_off,
                             input int st_a, input int st_b, input string tag);
        int n, nbits, stop_t, tot, w;
        int line_bad, busy_bad, first_t;
        logic act_l, exp_l, act_b, exp_b, fa, fe;
        bit p;
        logic pb, x;
        n = 5 + int'(cfg[1:0]);
        p = cfg[3];
        x = 1'b0;
        for (int i = 0; i < n; i++) x = x ^ d[i];
        case (cfg[5:4])
            2'b00: pb = ~x;
            2'b01: pb = x;
            2'b10: pb = 1'b1;
            default: pb = 1'b0;
        endcase
        stop_t = !cfg[2] ? 16 : (n == 5 ? 24 : 32);
        nbits  = 1 + n + (p ? 1 : 0);
        tot    = 16 * nbits + stop_t;
        wr(3'd3, cfg);
        wr(3'd0, d);
        w = 0;
        while (ser_out !== 1'b0 && w < 100) begin
            @(negedge clk);
            w++;
        end
        line_bad = 0; busy_bad = 0; first_t = -1; fa = 0; fe = 0;
        for (int t = 0; t < 300; t++) begin
            int miss, eff;
            miss = t - st_a;
            if (miss < 0) miss = 0;
            if (miss > st_b - st_a) miss = st_b - st_a;
            eff = t - miss;
            act_l = ser_out;
            act_b = tx_busy;
            if (t > brk_on && t <= brk_off) exp_l = 1'b0;
            else if (eff < 16 * nbits)      exp_l = frame_bit(eff / 16, d, n, p, pb);
            else                            exp_l = 1'b1;
            exp_b = (eff < tot);
            if (act_l !== exp_l) begin
                if (line_bad == 0) begin first_t = t; fa = act_l; fe = exp_l; end
                line_bad++;
            end
            if (act_b !== exp_b) busy_bad++;
            baud_tick = !(t >= st_a && t < st_b);
            if (t == brk_on) begin
                wr_en = 1'b1; addr = 3'd3; wdata = cfg | 8'h40;
            end else if (t == brk_off) begin
                wr_en = 1'b1; addr = 3'd3; wdata = cfg;
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        baud_tick = 1'b1;
        wr_en = 1'b0;
        check(line_bad == 0, {"R2/", tag}, $sformatf("line at cycle %0d cfg=%h data=%h", first_t, cfg, d),
              int'(fa), int'(fe));
        check(busy_bad == 0, {"R6/", tag}, $sformatf("busy cycles wrong in %0d cycles", busy_bad),
              busy_bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        string tag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(ser_out == 1'b1, "R1", "line idle", ser_out, 1);
        check(tx_busy == 1'b0, "R1", "busy", tx_busy, 0);
        check(thr_empty == 1'b1, "R1", "holding empty", thr_empty, 1);
        check(dl_value == 16'h0, "R1", "divisor", dl_value, 0);
        rd(3'd3, r);
        check(r == 8'h00, "R1", "config reset", r, 0);
        rd(3'd1, r);
        check(r == 8'h00, "R1", "ier reset", r, 0);

        // Vector table: one frame per entry
        for (int i = 0; i < 10; i++) begin
            logic [7:0] c;
            c = VEC[i][15:8];
            if (!c[3])               tag = "R3";
            else if (!c[5])          tag = "R4";
            else                     tag = "R5";
            run_frame(c, VEC[i][7:0], -1, -1, 1000, 1000, tag);
        end

        // R8 break during a frame, released mid-frame
        run_frame(8'h03, 8'hFF, 40, 90, 1000, 1000, "R8");
        // R7 stall of baud ticks during a frame
        run_frame(8'h0B, 8'h5C, -1, -1, 30, 70, "R7");

        // R8 break while idle
        wr(3'd3, 8'h40);
        @(negedge clk);
        check(ser_out == 1'b0, "R8", "idle break", ser_out, 0);
        wr(3'd3, 8'h00);
        @(negedge clk);
        check(ser_out == 1'b1, "R8", "break released", ser_out, 1);

        // R10 interrupt-enable field and data read
        wr(3'd1, 8'hFF);
        rd(3'd1, r);
        check(r == 8'h0F, "R10", "ier readback", r, 8'h0F);
        rd(3'd0, r);
        check(r == 8'h00, "R10", "data read", r, 0);

        // R9 divisor access
        wr(3'd3, 8'h80);
        wr(3'd0, 8'h34);
        wr(3'd1, 8'h12);
        check(dl_value == 16'h1234, "R9", "divisor output", dl_value, 16'h1234);
        rd(3'd0, r);
        check(r == 8'h34, "R9", "divisor low read", r, 8'h34);
        rd(3'd1, r);
        check(r == 8'h12, "R9", "divisor high read", r, 8'h12);
        rd(3'd3, r);
        check(r == 8'h80, "R11", "config readback", r, 8'h80);
        repeat (20) @(negedge clk);
        check(thr_empty == 1'b1, "R9", "no holding load", thr_empty, 1);
        check(tx_busy == 1'b0 && ser_out == 1'b1, "R9", "no frame sent",
              {tx_busy, ser_out}, 2'b01);
        wr(3'd3, 8'h1E);
        rd(3'd1, r);
        check(r == 8'h0F, "R9", "ier untouched", r, 8'h0F);
        rd(3'd3, r);
        check(r == 8'h1E, "R11", "config readback", r, 8'h1E);
        check(dl_value == 16'h1234, "R9", "divisor kept", dl_value, 16'h1234);

        // R10 holding load flags not-empty the next cycle
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd0; wdata = 8'h66;
        @(negedge clk);
        wr_en = 1'b0;
        check(thr_empty == 1'b0, "R10", "holding loaded", thr_empty, 0);
        repeat (300) @(negedge clk);
        check(tx_busy == 1'b0 && thr_empty == 1'b1, "R10", "frame drained",
              {tx_busy, thr_empty}, 2'b01);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule